// File: doc/BRIEF.md
# Dual-Ratio Clock Enable Divider

This block runs from one fast reference clock and produces two periodic enable strobes: a core-rate strobe and a slower system-rate strobe. Downstream logic stays on the reference clock and advances only in cycles where its strobe is high, so no new clock nets are created. A single configuration word holds both ratios. The core ratio is a power of two picked by a two-bit code. The system ratio is any whole number from 1 to 15.

Software may write a new configuration word at any moment and does not wait for a lock. Each write is checked against the rules that tie the two rates together. A word that breaks a rule is refused: the setting in force and any setting already queued stay as they were, and a sticky error flag is raised. An accepted word is queued, and `busy` stays high while it waits. It takes effect only at the end of a complete system period. At that point both counters wrap together, so neither strobe ever shows a shortened or stretched period. Because the system ratio is always a whole multiple of the core ratio, every system strobe falls in a cycle that also has a core strobe.

Top module: `clk_ratio_ctrl`

## Requirements
- R1: After reset the active setting is core code 00 with system divisor 5, `active_cfg` reads 6'b00_0101, and `busy` and `err` are low.
- R2: `core_en` is high for one cycle in every D reference cycles. D comes from `wr_data[5:4]` of the active setting: 00 gives 1, 01 gives 2, 10 gives 4, 11 gives 8.
- R3: `sys_en` is high for one cycle in every N reference cycles, where N is `wr_data[3:0]` of the active setting.
- R4: `sys_en` is only ever high in a cycle where `core_en` is also high.
- R5: A write with a system field of 0 is refused. The active and queued settings are left unchanged, and `err` goes high in the next cycle.
- R6: A write whose system field is below the parameter MIN_SYS_DIV, which caps the system rate, is refused in the same way as in R5.
- R7: A write where N is less than D, or where N is not a whole multiple of D, is refused in the same way as in R5.
- R8: An accepted write sets `busy` in the next cycle. The queued setting becomes active in the cycle after the first `sys_en` pulse that follows, and `busy` drops in that same cycle. Until then the old period runs to its end.
- R9: `active_cfg` always shows the setting in force, and it changes only in the cycle after a `sys_en` pulse.
- R10: An accepted write clears `err`. A later accepted write made while a setting is still queued replaces the queued one, so the last accepted word is the one that takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | One-cycle write strobe for the configuration word |
| wr_data | input | 6 | Configuration word: [5:4] core code, [3:0] system divisor |
| core_en | output | 1 | Core-rate enable strobe |
| sys_en | output | 1 | System-rate enable strobe |
| active_cfg | output | 6 | Setting currently in force, same layout as `wr_data` |
| busy | output | 1 | High while an accepted setting waits for its boundary |
| err | output | 1 | Sticky flag for a refused write, cleared by an accepted write |

## Verification
The bench builds the block with MIN_SYS_DIV set to 3 and keeps the four-bit system field and the two-bit core code. The raised floor lets one run exercise all of the refusal causes: a zero field, a field under the rate cap (2 with core code 00), a field smaller than the core divisor, and a field that is not a multiple of the core divisor. Every core code is used, including divide by 8 against 8, which is the tightest legal pairing. Writes are issued while a change is already queued and on cycles next to a system strobe, so the queue-replacement and boundary-timing cases are hit.

// File: rtl/ratio_pkg.sv
package ratio_pkg;
  localparam int unsigned SYS_FIELD_W  = 4;
  localparam int unsigned CORE_CODE_W  = 2;
  localparam int unsigned RST_SYS_DIV  = 5;
  localparam int unsigned RST_CORE_CODE = 0;

  typedef enum logic [1:0] {
    CORE_BY1 = 2'b00,
    CORE_BY2 = 2'b01,
    CORE_BY4 = 2'b10,
    CORE_BY8 = 2'b11
  } core_code_e;
endpackage

// File: rtl/ratio_guard.sv
module ratio_guard #(
  parameter int unsigned SYS_W       = 4,
  parameter int unsigned SEL_W       = 2,
  parameter int unsigned MIN_SYS_DIV = 1
) (
  input  logic [SYS_W-1:0] sys_div,
  input  logic [SEL_W-1:0] core_sel,
  output logic             legal
);
  // core divisor is 2**core_sel; system divisor must be a nonzero multiple
  // of it and must respect the system-rate ceiling
  logic [31:0] core_div;
  logic [31:0] sys_val;
  logic [31:0] low_mask;

  always_comb begin
    core_div = 32'd1 << core_sel;
    sys_val  = 32'(sys_div);
    low_mask = core_div - 32'd1;
    legal = (sys_val != 32'd0)
         && (sys_val >= 32'(MIN_SYS_DIV))
         && (sys_val >= core_div)
         && ((sys_val & low_mask) == 32'd0);
  end
endmodule

// File: rtl/div_counter.sv
module div_counter #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] last,
  output logic         wrap
);
  logic [W-1:0] cnt_q;

  assign wrap = (cnt_q == last);

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt_q <= '0;
    else if (wrap) cnt_q <= '0;
    else           cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/clk_ratio_ctrl.sv
module clk_ratio_ctrl #(
  parameter int unsigned SYS_W       = ratio_pkg::SYS_FIELD_W,
  parameter int unsigned SEL_W       = ratio_pkg::CORE_CODE_W,
  parameter int unsigned MIN_SYS_DIV = 1,
  parameter int unsigned RST_SYS     = ratio_pkg::RST_SYS_DIV,
  parameter int unsigned RST_SEL     = ratio_pkg::RST_CORE_CODE
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [SEL_W+SYS_W-1:0] wr_data,
  output logic                   core_en,
  output logic                   sys_en,
  output logic [SEL_W+SYS_W-1:0] active_cfg,
  output logic                   busy,
  output logic                   err
);
  localparam int unsigned CFG_W      = SEL_W + SYS_W;
  localparam int unsigned CORE_CNT_W = (1 << SEL_W) - 1;
  localparam logic [CFG_W-1:0] RST_CFG = {SEL_W'(RST_SEL), SYS_W'(RST_SYS)};

  logic [CFG_W-1:0]      act_q, pend_q;
  logic                  pend_vld_q, err_q;
  logic                  wr_legal, apply;
  logic [CORE_CNT_W-1:0] core_last;
  logic [SYS_W-1:0]      sys_last;

  ratio_guard #(
    .SYS_W(SYS_W), .SEL_W(SEL_W), .MIN_SYS_DIV(MIN_SYS_DIV)
  ) u_guard (
    .sys_div (wr_data[SYS_W-1:0]),
    .core_sel(wr_data[CFG_W-1:SYS_W]),
    .legal   (wr_legal)
  );

  assign core_last = CORE_CNT_W'((32'd1 << act_q[CFG_W-1:SYS_W]) - 32'd1);
  assign sys_last  = act_q[SYS_W-1:0] - 1'b1;

  div_counter #(.W(CORE_CNT_W)) u_core_cnt (
    .clk(clk), .rst_n(rst_n), .last(core_last), .wrap(core_en)
  );

  div_counter #(.W(SYS_W)) u_sys_cnt (
    .clk(clk), .rst_n(rst_n), .last(sys_last), .wrap(sys_en)
  );

  // both counters wrap together on a system strobe: the only safe boundary
  assign apply = pend_vld_q && sys_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q      <= RST_CFG;
      pend_q     <= RST_CFG;
      pend_vld_q <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      if (apply) act_q <= pend_q;
      if (wr_en && wr_legal) begin
        pend_q     <= wr_data;
        pend_vld_q <= 1'b1;
        err_q      <= 1'b0;
      end else begin
        if (wr_en) err_q <= 1'b1;
        if (apply) pend_vld_q <= 1'b0;
      end
    end
  end

  assign active_cfg = act_q;
  assign busy       = pend_vld_q;
  assign err        = err_q;
endmodule

// File: rtl/clk_ratio_ctrl_chk.sv
module clk_ratio_ctrl_chk #(
  parameter int unsigned SYS_W       = 4,
  parameter int unsigned SEL_W       = 2,
  parameter int unsigned MIN_SYS_DIV = 1
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   wr_en,
  input logic                   core_en,
  input logic                   sys_en,
  input logic [SEL_W+SYS_W-1:0] active_cfg,
  input logic                   busy,
  input logic                   err
);
  assert_sys_on_core_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sys_en |-> core_en);

  assert_cfg_boundary_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(active_cfg) |-> $past(sys_en));

  assert_busy_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(sys_en));

  assert_busy_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wr_en));

  assert_err_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> $past(wr_en));

  assert_active_floor_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(active_cfg[SYS_W-1:0]) >= 32'(MIN_SYS_DIV)) && (active_cfg[SYS_W-1:0] != '0));
endmodule

bind clk_ratio_ctrl clk_ratio_ctrl_chk #(
  .SYS_W(SYS_W), .SEL_W(SEL_W), .MIN_SYS_DIV(MIN_SYS_DIV)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .core_en(core_en),
  .sys_en(sys_en), .active_cfg(active_cfg), .busy(busy), .err(err)
);

// File: tb/clk_ratio_ctrl_tb.sv
module clk_ratio_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int MIN_DIV    = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [5:0] wr_data = '0;
  logic       core_en, sys_en, busy, err;
  logic [5:0] active_cfg;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  // behavioural reference state
  int m_ccnt, m_scnt, m_act_sys, m_act_sel, m_pend_sys, m_pend_sel;
  bit m_pend_v, m_err;

  always #(CLK_PERIOD/2) clk = ~clk;

  clk_ratio_ctrl #(.MIN_SYS_DIV(MIN_DIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .core_en(core_en), .sys_en(sys_en), .active_cfg(active_cfg),
    .busy(busy), .err(err)
  );

  function automatic bit ok_word(input int sys, input int sel);
    int d = 1 << sel;
    return (sys != 0) && (sys >= MIN_DIV) && (sys >= d) && ((sys % d) == 0);
  endfunction

  function automatic bit m_core_en();
    return m_ccnt == (1 << m_act_sel) - 1;
  endfunction

  function automatic bit m_sys_en();
    return m_scnt == m_act_sys - 1;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // reference model steps at each rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_ccnt = 0; m_scnt = 0; m_act_sys = 5; m_act_sel = 0;
      m_pend_sys = 5; m_pend_sel = 0; m_pend_v = 0; m_err = 0;
    end else begin
      bit ce, se, app;
      ce  = m_core_en();
      se  = m_sys_en();
      app = se && m_pend_v;
      m_ccnt = ce ? 0 : m_ccnt + 1;
      m_scnt = se ? 0 : m_scnt + 1;
      if (app) begin
        m_act_sys = m_pend_sys; m_act_sel = m_pend_sel;
        m_pend_v = 0;
      end
      if (wr_en) begin
        if (ok_word(int'(wr_data[3:0]), int'(wr_data[5:4]))) begin
          m_pend_sys = int'(wr_data[3:0]); m_pend_sel = int'(wr_data[5:4]);
          m_pend_v = 1; m_err = 0;
        end else m_err = 1;
      end
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      check("R2 core_en", int'(core_en), int'(m_core_en()));
      check("R3 sys_en", int'(sys_en), int'(m_sys_en()));
      check("R9 active_cfg", int'(active_cfg), (m_act_sel << 4) | m_act_sys);
      check("R8 busy", int'(busy), int'(m_pend_v));
      check("R5 err", int'(err), int'(m_err));
      if (sys_en) check("R4 sys_en without core_en", int'(core_en), 1);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=<150000", cycles);
      summary();
    end
  end

  task automatic write_word(input int sel, input int sys);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = 6'((sel << 4) | sys);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_applied();
    for (int i = 0; i < 64 && busy; i++) @(negedge clk);
    check("R8 busy clears", int'(busy), 0);
  endtask

  task automatic measure_sys(input string tag, input int exp);
    int gap;
    while (!sys_en) @(negedge clk);
    @(negedge clk);
    gap = 1;
    while (!sys_en && gap < 40) begin @(negedge clk); gap++; end
    check(tag, gap, exp);
  endtask

  initial begin
    idle(3);
    @(negedge clk);
    rst_n = 1'b1;
    check("R1 reset active_cfg", int'(active_cfg), 6'b00_0101);
    check("R1 reset busy", int'(busy), 0);
    check("R1 reset err", int'(err), 0);
    measure_sys("R3 default period", 5);

    write_word(1, 6);
    check("R8 busy after accept", int'(busy), 1);
    check("R9 old setting held", int'(active_cfg), 6'h05);
    wait_applied();
    check("R2 applied code 01", int'(active_cfg), 6'h16);
    measure_sys("R3 period 6", 6);

    write_word(3, 8);
    wait_applied();
    measure_sys("R3 period 8 with core 8", 8);

    write_word(2, 12);
    wait_applied();
    measure_sys("R3 period 12", 12);

    write_word(0, 0);
    check("R5 zero field err", int'(err), 1);
    check("R5 zero field busy", int'(busy), 0);
    check("R5 zero field active", int'(active_cfg), 6'h2C);

    write_word(0, 2);
    check("R6 below floor err", int'(err), 1);
    check("R6 below floor active", int'(active_cfg), 6'h2C);

    write_word(3, 4);
    check("R7 sys below core err", int'(err), 1);
    write_word(2, 6);
    check("R7 non-multiple err", int'(err), 1);
    check("R7 non-multiple busy", int'(busy), 0);
    idle(15);
    check("R7 active unchanged", int'(active_cfg), 6'h2C);

    write_word(0, 15);
    check("R10 err cleared", int'(err), 0);
    write_word(1, 4);
    write_word(0, 7);
    write_word(0, 1);
    check("R10 rejected keeps queue busy", int'(busy), 1);
    wait_applied();
    check("R10 last accepted wins", int'(active_cfg), 6'h07);
    measure_sys("R3 period 7", 7);

    write_word(0, 3);
    wait_applied();
    measure_sys("R6 floor value accepted", 3);

    for (int k = 0; k < 6; k++) begin
      write_word(k % 4, 8);
      idle(k);
    end
    wait_applied();
    idle(40);
    summary();
  end
endmodule